// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port with its own interrupt logic. Software reaches it through a plain single-cycle register bus. Through that bus it sets an output value latch and a per-pin output-enable mask, and it reads back the pad levels after synchronization. Each pin can raise an interrupt on one of four conditions: a low level, a high level, a rising transition or a falling transition.

Pad inputs pass through a two-stage synchronizer. Transitions are then found by comparing the synchronized value with its value one cycle earlier. Every detected condition sets a sticky flag, and software clears a flag by writing a one to it. A per-pin enable word decides which flags reach the interrupt lines. Pins 0 to 15 drive one line and pins 16 to 31 drive another, so each half can be serviced on its own. A third line is the OR of the two, for systems that wire a single request.

Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, every register reads zero. All pins are inputs (`pad_oe` = 0), `pad_out` = 0 and all three interrupt lines are low.
- R2: A write to offset 0x00 sets the output value (`pad_out`). A write to offset 0x04 sets the per-pin output enable (`pad_oe`, 1 = drive). Both read back as written.
- R3: Offset 0x08 returns `pad_in` as sampled by the two-stage synchronizer. A pad change becomes visible after the second rising clock edge.
- R4: Pin p takes its 2-bit trigger code from offset 0x0C when p < 16, and from offset 0x10 otherwise. The code sits at bits [2*(p mod 16)+1 : 2*(p mod 16)]. The codes are: 0 = low level, 1 = high level, 2 = rising transition, 3 = falling transition.
- R5: A level-triggered pin sets its flag on every cycle that its synchronized value is at the active level, including the cycle right after a clear.
- R6: An edge-triggered pin sets its flag once for each matching transition of its synchronized value, and never because of a static level.
- R7: Writing to offset 0x18 clears each flag whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged.
- R8: If a clear and a new trigger hit the same flag in the same cycle, the flag stays set.
- R9: `irq_lo` is high when any of pins 0–15 has its flag set and its enable bit (offset 0x14, 1 = enabled) set. `irq_hi` does the same for pins 16–31. `irq_any` is their OR. An enable word of zero keeps all three lines low.
- R10: A write to offset 0x08 changes nothing. The register keeps returning the synchronized pad value.
- R11: Reading an offset with no register returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output value latch |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt request for pins 0–15 |
| irq_hi | output | 1 | Interrupt request for pins 16–31 |
| irq_any | output | 1 | OR of `irq_lo` and `irq_hi` |

## Verification
A register write is visible on the bus and on `pad_out`/`pad_oe` from the edge that samples the strobe. A pad change reaches the pad-status read after two rising edges, and it reaches a flag and the interrupt lines after three. The bench drives every stimulus on a falling edge and always waits at least four rising edges before sampling a trigger result, also on a falling edge. It checks the pad-status latency exactly, at one edge (still the old value) and at two edges (the new value). Clears are checked on the falling edge right after the edge that applies them, which is the cycle in which a level trigger must already have set the flag again.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // register byte offsets (the software view depends on these)
  localparam logic [4:0] OFS_OUT_VAL = 5'h00;
  localparam logic [4:0] OFS_OUT_EN  = 5'h04;
  localparam logic [4:0] OFS_PAD_LVL = 5'h08;
  localparam logic [4:0] OFS_TRIG_LO = 5'h0C;
  localparam logic [4:0] OFS_TRIG_HI = 5'h10;
  localparam logic [4:0] OFS_IRQ_EN  = 5'h14;
  localparam logic [4:0] OFS_FLAGS   = 5'h18;

  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW  = 2'd0,
    TRIG_LEVEL_HIGH = 2'd1,
    TRIG_RISE       = 2'd2,
    TRIG_FALL       = 2'd3
  } trig_code_e;

  // does a pin with code `code` see its condition this cycle?
  function automatic logic trig_hit(input logic [1:0] code,
                                    input logic now_v,
                                    input logic old_v);
    case (trig_code_e'(code))
      TRIG_LEVEL_LOW:  trig_hit = !now_v;
      TRIG_LEVEL_HIGH: trig_hit = now_v;
      TRIG_RISE:       trig_hit = now_v && !old_v;
      default:         trig_hit = !now_v && old_v;
    endcase
  endfunction

  // code bit 1 marks the transition-sensitive codes
  function automatic logic is_edge_code(input logic [1:0] code);
    is_edge_code = code[1];
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_raw,
  output logic [WIDTH-1:0] lvl_now,
  output logic [WIDTH-1:0] lvl_old
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] hist_q;
  logic [1:0]       warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
      warm_q <= '0;
    end else begin
      meta_q <= pad_raw;
      sync_q <= meta_q;
      hist_q <= sync_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
  end

  assign lvl_now = sync_q;
  assign lvl_old = hist_q;

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (lvl_now == $past(pad_raw, 2))); // R3

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   lvl_now,
  input  logic [NPINS-1:0]   lvl_old,
  input  logic [2*NPINS-1:0] trig_cfg,
  output logic [NPINS-1:0]   trig_evt
);
  logic [NPINS-1:0] edge_sel;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign trig_evt[p] = trig_hit(trig_cfg[2*p +: 2], lvl_now[p], lvl_old[p]);
    assign edge_sel[p] = is_edge_code(trig_cfg[2*p +: 2]);
  end

  // a transition trigger never fires on two cycles in a row under a fixed code
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(trig_cfg) |-> ((trig_evt & $past(trig_evt) & edge_sel) == '0)); // R6

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] trig_evt,
  input  logic [NPINS-1:0] clr_vec,
  input  logic [NPINS-1:0] irq_en,
  output logic [NPINS-1:0] flags,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] flags_q;
  logic [NPINS-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_vec) | trig_evt;
  end

  assign flags  = flags_q;
  assign pend   = flags_q & irq_en;
  assign irq_lo = |pend[HALF-1:0];
  assign irq_hi = |pend[NPINS-1:HALF];

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(clr_vec & ~trig_evt)) == '0)); // R7

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(trig_evt)) == $past(trig_evt))); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec))); // R7

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              irq_any
);
  logic [NPINS-1:0] out_val_q, out_en_q, trig_lo_q, trig_hi_q, irq_en_q;
  logic [NPINS-1:0] lvl_now, lvl_old, trig_evt, flags, clr_vec;
  logic wr_out_val, wr_out_en, wr_trig_lo, wr_trig_hi, wr_irq_en, wr_flags;

  assign wr_out_val = bus_wr && (bus_addr == OFS_OUT_VAL);
  assign wr_out_en  = bus_wr && (bus_addr == OFS_OUT_EN);
  assign wr_trig_lo = bus_wr && (bus_addr == OFS_TRIG_LO);
  assign wr_trig_hi = bus_wr && (bus_addr == OFS_TRIG_HI);
  assign wr_irq_en  = bus_wr && (bus_addr == OFS_IRQ_EN);
  assign wr_flags   = bus_wr && (bus_addr == OFS_FLAGS);
  assign clr_vec    = wr_flags ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_val_q <= '0;
      out_en_q  <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      irq_en_q  <= '0;
    end else begin
      if (wr_out_val) out_val_q <= bus_wdata;
      if (wr_out_en)  out_en_q  <= bus_wdata;
      if (wr_trig_lo) trig_lo_q <= bus_wdata;
      if (wr_trig_hi) trig_hi_q <= bus_wdata;
      if (wr_irq_en)  irq_en_q  <= bus_wdata;
    end
  end

  gpio_pad_sync #(.WIDTH(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_raw (pad_in),
    .lvl_now (lvl_now),
    .lvl_old (lvl_old)
  );

  gpio_trig_detect #(.NPINS(NPINS)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_now  (lvl_now),
    .lvl_old  (lvl_old),
    .trig_cfg ({trig_hi_q, trig_lo_q}),
    .trig_evt (trig_evt)
  );

  gpio_irq_status #(.NPINS(NPINS)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_evt (trig_evt),
    .clr_vec  (clr_vec),
    .irq_en   (irq_en_q),
    .flags    (flags),
    .irq_lo   (irq_lo),
    .irq_hi   (irq_hi)
  );

  assign irq_any = irq_lo || irq_hi;
  assign pad_out = out_val_q;
  assign pad_oe  = out_en_q;

  always_comb begin
    case (bus_addr)
      OFS_OUT_VAL: bus_rdata = out_val_q;
      OFS_OUT_EN:  bus_rdata = out_en_q;
      OFS_PAD_LVL: bus_rdata = lvl_now;
      OFS_TRIG_LO: bus_rdata = trig_lo_q;
      OFS_TRIG_HI: bus_rdata = trig_hi_q;
      OFS_IRQ_EN:  bus_rdata = irq_en_q;
      OFS_FLAGS:   bus_rdata = flags;
      default:     bus_rdata = '0;
    endcase
  end

  AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq_en && (bus_wdata == '0)) |=> !irq_any); // R9

  AST_PAD_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_val |=> (pad_out == $past(bus_wdata))); // R2

endmodule

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi, irq_any;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port u_gpio_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .irq_any(irq_any)
  );

  // stimulus table: {pin[4:0], code[1:0], level_before, level_after}
  localparam int NVEC = 8;
  localparam logic [8:0] VEC [NVEC] = '{
    {5'd3,  2'd0, 1'b1, 1'b0},
    {5'd20, 2'd0, 1'b0, 1'b1},
    {5'd7,  2'd1, 1'b0, 1'b1},
    {5'd31, 2'd1, 1'b1, 1'b0},
    {5'd0,  2'd2, 1'b0, 1'b1},
    {5'd16, 2'd2, 1'b1, 1'b0},
    {5'd15, 2'd3, 1'b1, 1'b0},
    {5'd27, 2'd3, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // level-active from the code definitions of R4
  function automatic bit lvl_active(input logic [1:0] code, input logic v);
    return (code == 2'd0) ? !v : (code == 2'd1) ? v : 1'b0;
  endfunction

  function automatic logic [31:0] cfg_word(input int pin, input logic [1:0] code,
                                           input bit upper);
    logic [31:0] w = 32'hAAAA_AAAA;      // every pin: rising edge
    if ((pin >= 16) == upper) w[2*(pin%16) +: 2] = code;
    return w;
  endfunction

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    // R1: reset state
    cycles(2);
    for (int a = 0; a < 7; a++) begin
      rd(5'(4*a), r);
      check(r == 0, "R1 reg", r, 0);
    end
    check(pad_oe == 0 && pad_out == 0, "R1 pads", pad_oe | pad_out, 0);
    check({irq_lo, irq_hi, irq_any} == 0, "R1 irq", {29'd0, irq_lo, irq_hi, irq_any}, 0);
    @(negedge clk); rst_n = 1'b1;
    // all pins rising, nothing pending
    wr(5'h0C, 32'hAAAA_AAAA); wr(5'h10, 32'hAAAA_AAAA);
    cycles(4); wr(5'h18, 32'hFFFF_FFFF);

    // R2
    wr(5'h00, 32'hDEAD_BEEF); wr(5'h04, 32'h0F0F_1234);
    rd(5'h00, r); check(r == 32'hDEAD_BEEF && pad_out == r, "R2 out", r, 32'hDEAD_BEEF);
    rd(5'h04, r); check(r == 32'h0F0F_1234 && pad_oe == r, "R2 oe", r, 32'h0F0F_1234);
    // R11
    rd(5'h1C, r); check(r == 0, "R11 unmapped", r, 0);

    // R3 latency; R10 read-only
    wr(5'h0C, 32'hFFFF_FFFF); wr(5'h10, 32'hFFFF_FFFF);   // falling: no event on rise
    pad_in = 32'h1234_5678;
    @(negedge clk); rd(5'h08, r); check(r == 0, "R3 one edge", r, 0);
    @(negedge clk); rd(5'h08, r); check(r == 32'h1234_5678, "R3 two edges", r, 32'h1234_5678);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, r); check(r == 32'h1234_5678, "R10 ro", r, 32'h1234_5678);
    pad_in = '0; cycles(4);
    wr(5'h0C, 32'hAAAA_AAAA); wr(5'h10, 32'hAAAA_AAAA);
    wr(5'h18, 32'hFFFF_FFFF);

    // table walk: R4, R5, R6, R9
    for (int v = 0; v < NVEC; v++) begin
      int pin = int'(VEC[v][8:4]);
      logic [1:0] code = VEC[v][3:2];
      logic bef = VEC[v][1];
      logic aft = VEC[v][0];
      bit exp_a, exp_b;
      pad_in = '0;
      wr(5'h0C, cfg_word(pin, code, 1'b0));
      wr(5'h10, cfg_word(pin, code, 1'b1));
      cycles(4);
      pad_in[pin] = bef;
      cycles(4);
      wr(5'h18, 32'hFFFF_FFFF);
      exp_a = lvl_active(code, bef);
      rd(5'h18, r);
      check(r == (32'(exp_a) << pin), "R5/R6 after clear", r, 32'(exp_a) << pin);
      wr(5'h14, 32'd1 << pin);
      pad_in[pin] = aft;
      cycles(4);
      if (code[1]) exp_b = (code == 2'd2) ? (!bef && aft) : (bef && !aft);
      else         exp_b = lvl_active(code, bef) || lvl_active(code, aft);
      rd(5'h18, r);
      check(r == (32'(exp_b) << pin), "R4 flag", r, 32'(exp_b) << pin);
      check(irq_lo == (exp_b && pin < 16) && irq_hi == (exp_b && pin >= 16) && irq_any == exp_b,
            "R9 lines", {29'd0, irq_lo, irq_hi, irq_any},
            {29'd0, exp_b && pin < 16, exp_b && pin >= 16, exp_b});
      wr(5'h14, 32'd0);
      pad_in = '0;
      cycles(4);
      wr(5'h0C, 32'hAAAA_AAAA); wr(5'h10, 32'hAAAA_AAAA);
      wr(5'h18, 32'hFFFF_FFFF);
    end

    // R8 / R5: level high persists through a clear
    wr(5'h0C, 32'hAAAA_AAA6);             // pin 1 high level
    pad_in[1] = 1'b1; cycles(4);
    wr(5'h18, 32'h0000_0002);
    rd(5'h18, r); check(r == 32'h2, "R8 event wins", r, 32'h2);
    pad_in[1] = 1'b0; cycles(4);
    wr(5'h18, 32'h0000_0002);
    rd(5'h18, r); check(r == 0, "R5 clears when idle", r, 0);

    // R7: zeros do not clear; ones clear
    wr(5'h0C, 32'hAAAA_AAAA);
    pad_in[9] = 1'b1; cycles(4);
    rd(5'h18, r); check(r == 32'h200, "R6 rise", r, 32'h200);
    wr(5'h18, 32'h0);
    rd(5'h18, r); check(r == 32'h200, "R7 zero write", r, 32'h200);
    wr(5'h18, 32'h100);
    rd(5'h18, r); check(r == 32'h200, "R7 other bit", r, 32'h200);
    cycles(3);
    rd(5'h18, r); check(r == 32'h200, "R6 no refire", r, 32'h200);
    // R9: mask zero keeps lines low
    wr(5'h14, 32'h0);
    check(!irq_any && !irq_lo, "R9 masked", {31'd0, irq_any}, 0);
    wr(5'h14, 32'h200);
    check(irq_lo && !irq_hi && irq_any, "R9 enabled", {29'd0, irq_lo, irq_hi, irq_any}, 32'h5);
    wr(5'h18, 32'h200);
    rd(5'h18, r); check(r == 0 && !irq_any, "R7 clear", r, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule